// File: doc/BRIEF.md
# Flash region write-protection controller

This block sits in front of a 64 KiB flash array and decides whether each program, sector-erase or mass-erase request may proceed. It holds an 8-bit protection setting that is copied from a nonvolatile byte while reset is asserted. After reset, software may rewrite the setting, but only in ways that keep or tighten protection. Two windows can be defined: one anchored at the top of the array and one starting at offset 0. A mode bit selects their meaning. With the mode bit at 1, an enabled window is the protected area. With the mode bit at 0, an enabled window is the only area left writable.

A request that would alter protected content is refused, and a sticky violation flag is raised on the next clock edge. While that flag is set, every modifying request is refused without further effect, until software clears the flag. Reads always pass. The allow output is combinational from the current setting and the request.

Top module: `flash_guard`

## Requirements
- R1: While `rst_n` is low the setting is loaded from `nv_byte` and the violation flag is 0.
- R2: `prot_value` shows the setting with these bit positions: bit 7 mode, bit 6 spare, bit 5 top-window disable, bits 4:3 top-window size code, bit 2 bottom-window disable, bits 1:0 bottom-window size code. Bit 6 keeps its reset value across writes.
- R3: With mode = 1, an address lies in a protected region when its window's disable bit is 0 and the address is inside that window. The top window covers the highest 2 KiB << code bytes. The bottom window covers addresses below 512 << code. All other addresses are writable.
- R4: With mode = 0, an address is writable only when it lies inside a window whose disable bit is 0. Every other address is protected, which means the whole array is protected when both disable bits are 1.
- R5: A register write changes a size code only if that window's disable bit was 1 before the write. Otherwise the size code keeps its value.
- R6: The mode bit and both disable bits can be cleared by a write but never set again until reset.
- R7: Program (`cmd_type` 01) or sector erase (10) at a protected address gives `cmd_allow` = 0, and `viol_flag` is 1 after the next rising edge.
- R8: Mass erase (11) is allowed only when the mode bit and both disable bits are 1. Otherwise it is refused and sets the flag.
- R9: The flag stays set until a cycle with `flag_clr` = 1. While it is set, every modifying request is refused, and the refusal leaves the flag unchanged.
- R10: A read (`cmd_type` 00) with `cmd_valid` = 1 is always allowed.
- R11: A request in the same cycle as a register write is judged against the setting before the write. The new setting takes effect on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; the setting loads while low |
| nv_byte | input | 8 | Nonvolatile protection byte copied during reset |
| wr_en | input | 1 | Software write strobe for the setting |
| wr_data | input | 8 | Write data for the setting |
| flag_clr | input | 1 | Write-one strobe that clears the violation flag |
| cmd_valid | input | 1 | Request present this cycle |
| cmd_type | input | 2 | 00 read, 01 program, 10 sector erase, 11 mass erase |
| cmd_addr | input | ADDR_W | Target byte offset in the array |
| cmd_allow | output | 1 | Request may proceed (combinational) |
| viol_flag | output | 1 | Sticky protection-violation flag |
| prot_value | output | 8 | Current protection setting |

## Verification
A register write and a request decision can fall in the same cycle. The write may tighten the bottom window exactly over the address being programmed. The bench provokes this by raising `wr_en` and a program request on one clock. It then expects the request to be allowed under the old setting, and a repeat of the same request one cycle later to be refused with the flag raised. A behavioural model in the bench recomputes window bounds with integer arithmetic and compares allow, flag and setting on every clock.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    CMD_READ = 2'd0,
    CMD_PROG = 2'd1,
    CMD_SECT = 2'd2,
    CMD_MASS = 2'd3
  } cmd_e;

  // Field positions matter: software encodes writes with them.
  typedef struct packed {
    logic       open;
    logic       spare;
    logic       hdis;
    logic [1:0] hsz;
    logic       ldis;
    logic [1:0] lsz;
  } prot_t;

  // Top window: the highest (1 << (unit_lg + code)) bytes of a 2**aw array.
  function automatic logic in_high_win(input logic [31:0] addr, input logic [1:0] code,
                                       input int aw, input int unit_lg);
    logic [63:0] span;
    logic [63:0] top;
    span = 64'd1 << (unit_lg + int'(code));
    top  = 64'd1 << aw;
    return {32'd0, addr} >= (top - span);
  endfunction

  // Bottom window: offsets below (1 << (unit_lg + code)).
  function automatic logic in_low_win(input logic [31:0] addr, input logic [1:0] code,
                                      input int unit_lg);
    logic [63:0] span;
    span = 64'd1 << (unit_lg + int'(code));
    return {32'd0, addr} < span;
  endfunction

endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  prot_t nv_val,
  input  logic  wr_en,
  input  prot_t wr_val,
  output prot_t prot_q
);

  prot_t nxt;

  always_comb begin
    nxt       = prot_q;
    nxt.open  = prot_q.open & wr_val.open;
    nxt.hdis  = prot_q.hdis & wr_val.hdis;
    nxt.ldis  = prot_q.ldis & wr_val.ldis;
    if (prot_q.hdis) nxt.hsz = wr_val.hsz;
    if (prot_q.ldis) nxt.lsz = wr_val.lsz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prot_q <= nv_val;
    else if (wr_en) prot_q <= nxt;
  end

endmodule

// File: rtl/flash_guard_decode.sv
module flash_guard_decode
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int HI_UNIT_LG = 11,
  parameter int LO_UNIT_LG = 9
) (
  input  prot_t             prot,
  input  logic              flag,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              allow,
  output logic              viol_evt
);

  localparam int NWIN = 2;  // index 1 = top window, index 0 = bottom window

  cmd_e            ct;
  logic [31:0]     addr32;
  logic [NWIN-1:0] dis;
  logic [NWIN-1:0] hit;
  logic            window_on;
  logic            addr_prot;
  logic            mass_ok;
  logic            blocked;
  logic            modifying;

  assign ct     = cmd_e'(cmd_type);
  assign addr32 = 32'(cmd_addr);
  assign dis    = {prot.hdis, prot.ldis};

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    if (g == 1) begin : g_hi
      assign hit[g] = in_high_win(addr32, prot.hsz, ADDR_W, HI_UNIT_LG);
    end else begin : g_lo
      assign hit[g] = in_low_win(addr32, prot.lsz, LO_UNIT_LG);
    end
  end

  assign window_on = |(~dis & hit);
  assign addr_prot = prot.open ? window_on : ~window_on;
  assign mass_ok   = prot.open & prot.hdis & prot.ldis;
  assign blocked   = (ct == CMD_MASS) ? ~mass_ok : addr_prot;
  assign modifying = cmd_valid && (ct != CMD_READ);

  assign allow    = cmd_valid && ((ct == CMD_READ) || (!flag && !blocked));
  assign viol_evt = modifying && !flag && blocked;

endmodule

// File: rtl/flash_guard_flag.sv
module flash_guard_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_evt,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (viol_evt) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int HI_UNIT_LG = 11,
  parameter int LO_UNIT_LG = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        nv_byte,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              flag_clr,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_allow,
  output logic              viol_flag,
  output logic [7:0]        prot_value
);

  prot_t prot_q;
  logic  viol_evt;

  flash_guard_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .nv_val (prot_t'(nv_byte)),
    .wr_en  (wr_en),
    .wr_val (prot_t'(wr_data)),
    .prot_q (prot_q)
  );

  flash_guard_decode #(
    .ADDR_W     (ADDR_W),
    .HI_UNIT_LG (HI_UNIT_LG),
    .LO_UNIT_LG (LO_UNIT_LG)
  ) u_decode (
    .prot      (prot_q),
    .flag      (viol_flag),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .cmd_addr  (cmd_addr),
    .allow     (cmd_allow),
    .viol_evt  (viol_evt)
  );

  flash_guard_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .viol_evt (viol_evt),
    .clr      (flag_clr),
    .flag     (viol_flag)
  );

  assign prot_value = prot_q;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_clr,
  input logic       cmd_valid,
  input logic [1:0] cmd_type,
  input logic       cmd_allow,
  input logic       viol_flag,
  input logic [7:0] prot_value
);

  // R10
  read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'd0) |-> cmd_allow);

  // R8
  mass_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'd3 && cmd_allow) |->
      (prot_value[7] && prot_value[5] && prot_value[2]));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !flag_clr) |=> viol_flag);

  // R9
  flag_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && cmd_valid && cmd_type != 2'd0) |-> !cmd_allow);

  // R7
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag) |-> $past(cmd_valid && cmd_type != 2'd0 && !cmd_allow));

  // R6
  hdis_oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(prot_value[5]));

  // R6
  mode_oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(prot_value[7]));

  // R5
  hsz_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_value[5] |=> $stable(prot_value[4:3]));

  // R5
  lsz_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_value[2] |=> $stable(prot_value[1:0]));

endmodule

bind flash_guard flash_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flag_clr   (flag_clr),
  .cmd_valid  (cmd_valid),
  .cmd_type   (cmd_type),
  .cmd_allow  (cmd_allow),
  .viol_flag  (viol_flag),
  .prot_value (prot_value)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  nv_in;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        flag_clr;
  logic        cmd_valid;
  logic [1:0]  cmd_type;
  logic [15:0] cmd_addr;
  logic        cmd_allow;
  logic        viol_flag;
  logic [7:0]  prot_value;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_reg;
  logic       m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_byte    (nv_in),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .flag_clr   (flag_clr),
    .cmd_valid  (cmd_valid),
    .cmd_type   (cmd_type),
    .cmd_addr   (cmd_addr),
    .cmd_allow  (cmd_allow),
    .viol_flag  (viol_flag),
    .prot_value (prot_value)
  );

  // ---------------- reference model ----------------
  function automatic bit m_addr_protected(input logic [7:0] r, input int addr);
    int  hi_floor;
    int  lo_limit;
    bit  hi_en;
    bit  lo_en;
    hi_floor = 65536 - 2048 * (2 ** int'(r[4:3]));
    lo_limit = 512 * (2 ** int'(r[1:0]));
    hi_en = (r[5] == 1'b0) && (addr >= hi_floor);
    lo_en = (r[2] == 1'b0) && (addr < lo_limit);
    if (r[7]) return hi_en || lo_en;
    return !(hi_en || lo_en);
  endfunction

  function automatic bit m_blocked();
    if (cmd_type == 2'd3) return !(m_reg[7] && m_reg[5] && m_reg[2]);
    return m_addr_protected(m_reg, int'(cmd_addr));
  endfunction

  function automatic bit m_allow();
    if (!cmd_valid) return 1'b0;
    if (cmd_type == 2'd0) return 1'b1;
    if (m_flag) return 1'b0;
    return !m_blocked();
  endfunction

  function automatic logic [7:0] m_write(input logic [7:0] old, input logic [7:0] d);
    logic [7:0] r;
    r = old;
    if (!d[7]) r[7] = 1'b0;
    if (!d[5]) r[5] = 1'b0;
    if (!d[2]) r[2] = 1'b0;
    if (old[5]) r[4:3] = d[4:3];
    if (old[2]) r[1:0] = d[1:0];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg  <= nv_in;
      m_flag <= 1'b0;
    end else begin
      if (wr_en) m_reg <= m_write(m_reg, wr_data);
      if (cmd_valid && cmd_type != 2'd0 && !m_flag && m_blocked()) m_flag <= 1'b1;
      else if (flag_clr) m_flag <= 1'b0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit wr, input logic [7:0] wd, input bit clr,
                      input bit v, input logic [1:0] ty, input logic [15:0] a);
    @(negedge clk);
    check(tag, "flag", {7'd0, viol_flag}, {7'd0, m_flag});
    check(tag, "setting", prot_value, m_reg);
    wr_en = wr; wr_data = wd; flag_clr = clr;
    cmd_valid = v; cmd_type = ty; cmd_addr = a;
    #1;
    check(tag, "allow", {7'd0, cmd_allow}, {7'd0, m_allow()});
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 16'h0000);
  endtask

  task automatic expect_bit(input string tag, input string what, input logic act, input logic exp);
    check(tag, what, {7'd0, act}, {7'd0, exp});
  endtask

  task automatic do_reset(input logic [7:0] nv);
    @(negedge clk);
    wr_en = 0; wr_data = 0; flag_clr = 0; cmd_valid = 0; cmd_type = 0; cmd_addr = 0;
    nv_in = nv;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nv_in = 8'hFF;
    wr_en = 0; wr_data = 0; flag_clr = 0; cmd_valid = 0; cmd_type = 0; cmd_addr = 0;

    // R1 R2: open setting, nothing protected
    do_reset(8'hFF);
    idle("R1");
    @(negedge clk);
    expect_bit("R1", "flag after reset", viol_flag, 1'b0);
    check("R1", "loaded setting", prot_value, 8'hFF);
    step("R8", 1'b0, 8'h00, 1'b0, 1'b1, 2'd3, 16'h0000);
    expect_bit("R8", "mass erase open", cmd_allow, 1'b1);
    step("R3", 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 16'hFFFF);
    expect_bit("R3", "top unprotected", cmd_allow, 1'b1);

    // R5: size codes writable while disabled; spare bit kept (R2)
    step("R5", 1'b1, 8'hB5, 1'b0, 1'b0, 2'd0, 16'h0);
    idle("R5");
    check("R2", "spare kept", prot_value, 8'hF5);

    // R3 R7: enable 8 KiB top window
    step("R3", 1'b1, 8'hD5, 1'b0, 1'b0, 2'd0, 16'h0);
    step("R7", 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 16'hE000);
    expect_bit("R7", "program in window", cmd_allow, 1'b0);
    step("R9", 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 16'h1000);
    expect_bit("R7", "flag raised", viol_flag, 1'b1);
    expect_bit("R9", "rejected while flagged", cmd_allow, 1'b0);
    step("R10", 1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 16'hE000);
    expect_bit("R10", "read while flagged", cmd_allow, 1'b1);
    step("R9", 1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0);
    step("R3", 1'b0, 8'h00, 1'b0, 1'b1, 2'd2, 16'hDFFF);
    expect_bit("R9", "flag cleared", viol_flag, 1'b0);
    expect_bit("R3", "below window", cmd_allow, 1'b1);

    // R5 R6: locked size, one-way disables
    step("R5", 1'b1, 8'hDD, 1'b0, 1'b0, 2'd0, 16'h0);
    step("R6", 1'b1, 8'hF5, 1'b0, 1'b0, 2'd0, 16'h0);
    idle("R6");
    check("R6", "disable stays clear", prot_value, 8'hD5);
    step("R8", 1'b0, 8'h00, 1'b0, 1'b1, 2'd3, 16'h0);
    expect_bit("R8", "mass erase refused", cmd_allow, 1'b0);
    step("R8", 1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0);

    // R11: write and request together
    step("R11", 1'b1, 8'hD1, 1'b0, 1'b1, 2'd1, 16'h0100);
    expect_bit("R11", "old setting used", cmd_allow, 1'b1);
    step("R11", 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 16'h0100);
    expect_bit("R11", "new setting used", cmd_allow, 1'b0);
    step("R3", 1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0);
    step("R3", 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 16'h0400);
    expect_bit("R3", "above bottom window", cmd_allow, 1'b1);
    idle("R3");

    // R4: mode 0, both disabled -> all protected
    do_reset(8'h64);
    idle("R4");
    step("R4", 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 16'h8000);
    expect_bit("R4", "all protected", cmd_allow, 1'b0);
    step("R9", 1'b0, 8'h00, 1'b0, 1'b1, 2'd2, 16'h0000);
    expect_bit("R9", "flagged erase", cmd_allow, 1'b0);
    step("R9", 1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0);
    idle("R9");

    // R4: mode 0 islands (top 4 KiB, bottom 512 B)
    do_reset(8'h48);
    idle("R4");
    step("R4", 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 16'hF000);
    expect_bit("R4", "top island", cmd_allow, 1'b1);
    step("R4", 1'b0, 8'h00, 1'b0, 1'b1, 2'd2, 16'h01FF);
    expect_bit("R4", "bottom island", cmd_allow, 1'b1);
    step("R4", 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 16'hEFFF);
    expect_bit("R4", "outside island", cmd_allow, 1'b0);
    step("R4", 1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0);
    step("R4", 1'b0, 8'h00, 1'b0, 1'b1, 2'd2, 16'h0200);
    expect_bit("R4", "above bottom island", cmd_allow, 1'b0);
    step("R4", 1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0);
    idle("R4");

    // R6: mode bit only clears
    do_reset(8'hFF);
    idle("R6");
    step("R6", 1'b1, 8'h7F, 1'b0, 1'b0, 2'd0, 16'h0);
    step("R6", 1'b1, 8'hFF, 1'b0, 1'b0, 2'd0, 16'h0);
    idle("R6");
    check("R6", "mode stays clear", prot_value, 8'h7F);
    step("R4", 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 16'h4000);
    expect_bit("R4", "mode 0 all protected", cmd_allow, 1'b0);
    idle("R4");
    idle("R4");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule